// File: doc/BRIEF.md
# Push-Button Register File Editor

This block keeps a small bank of sixteen 8-bit words that an operator edits with four push buttons. Two buttons step a word pointer forward or backward. The other two buttons raise or lower the word under the pointer by one. Each such edit reads the word, adjusts it and writes it back into the bank.

A second, independent read port lets display logic scan the whole bank at any time, without disturbing the editor. The current pointer and the value of the selected word are also driven out, so they can be shown directly.

Debouncing of the buttons is the job of logic in front of this block. Display drivers are not part of it.

Top module: `btn_regfile_editor`

## Requirements
- R1: Synchronous reset clears the pointer, the selected-value output, the external read data and all sixteen words to 0.
- R2: A fresh press of button bit 3 alone adds one to the pointer, and the pointer wraps from 15 to 0.
- R3: A fresh press of button bit 2 alone subtracts one from the pointer, and the pointer wraps from 0 to 15.
- R4: A fresh press of button bit 1 alone adds one to the selected word, modulo 256, so 255 becomes 0.
- R5: A fresh press of button bit 0 alone subtracts one from the selected word, modulo 256, so 0 becomes 255.
- R6: While two or more button bits are high, nothing changes, and releasing some of them does not count as a press.
- R7: A button acts once per press, on its 0-to-1 transition. Holding it high on later cycles has no further effect.
- R8: The external read port is synchronous. After a rising edge, the read data holds the word at the address presented before that edge, whatever the pointer is.
- R9: When the external read address matches a word written on the same edge, the read data shows the old word after that edge and the new word after the next edge.
- R10: The pointer and selected-value outputs change on the same clock edge that accepts a press.
- R11: A button that is already high when reset is released is not treated as a press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_i | input | 4 | Button levels, 1 = pressed (bit 3 pointer up, bit 2 pointer down, bit 1 value up, bit 0 value down) |
| rd_addr_i | input | 4 | External read address |
| rd_data_o | output | 8 | External read data, registered |
| ptr_o | output | 4 | Current word pointer |
| val_o | output | 8 | Value of the word under the pointer |

## Verification
The bench drives the pointer and the stored values across both wrap boundaries. A design that saturates or overflows there shows 15 or 255 where 0 is expected, or the reverse.

It holds buttons high, presses several buttons at once and releases them one at a time. These cases expose a level-triggered design, which keeps counting, and a design that wrongly takes a partial release as a new press.

The same-address read-during-write case catches a port that forwards the new data one cycle early. A button held through reset catches an edge detector that treats release from reset as a press.

// File: rtl/btn_edit_pkg.sv
package btn_edit_pkg;
  localparam int BTN_N = 4;
  localparam int BIT_PTR_UP = 3;
  localparam int BIT_PTR_DN = 2;
  localparam int BIT_VAL_UP = 1;
  localparam int BIT_VAL_DN = 0;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_PTR_UP,
    ACT_PTR_DN,
    ACT_VAL_UP,
    ACT_VAL_DN
  } edit_act_e;
endpackage

// File: rtl/btn_press_detect.sv
module btn_press_detect
  import btn_edit_pkg::*;
(
  input  logic             clk_i,
  input  logic [BTN_N-1:0] btn_i,
  output logic [BTN_N-1:0] btn_prev_o,
  output edit_act_e        act_o
);
  logic [BTN_N-1:0] prev_q;
  logic [BTN_N-1:0] rise;
  logic             single;

  // Sampled even during reset so a held button is not a press afterwards (R11)
  always_ff @(posedge clk_i) prev_q <= btn_i;

  assign rise   = btn_i & ~prev_q;
  assign single = (btn_i != '0) && ((btn_i & (btn_i - 1'b1)) == '0);

  always_comb begin
    act_o = ACT_NONE;
    if (single && ((btn_i & rise) != '0)) begin
      unique case (1'b1)
        btn_i[BIT_PTR_UP]: act_o = ACT_PTR_UP;
        btn_i[BIT_PTR_DN]: act_o = ACT_PTR_DN;
        btn_i[BIT_VAL_UP]: act_o = ACT_VAL_UP;
        btn_i[BIT_VAL_DN]: act_o = ACT_VAL_DN;
        default:           act_o = ACT_NONE;
      endcase
    end
  end

  assign btn_prev_o = prev_q;
endmodule

// File: rtl/regfile_2p.sv
module regfile_2p #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] iaddr_i,
  output logic [DW-1:0] idata_o,
  input  logic [AW-1:0] xaddr_i,
  output logic [DW-1:0] xdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] xdata_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  // Read-first external port: a same-edge write becomes visible one edge later
  always_ff @(posedge clk_i) begin
    if (rst_i) xdata_q <= '0;
    else       xdata_q <= mem[xaddr_i];
  end

  assign idata_o = mem[iaddr_i];
  assign xdata_o = xdata_q;
endmodule

// File: rtl/edit_ctrl.sv
module edit_ctrl
  import btn_edit_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  edit_act_e     act_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW-1:0] ptr_o,
  output logic [DW-1:0] val_o
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] val_q;

  always_comb begin
    ptr_d   = ptr_q;
    we_o    = 1'b0;
    wdata_o = rdata_i;
    unique case (act_i)
      ACT_PTR_UP: ptr_d = ptr_q + 1'b1;
      ACT_PTR_DN: ptr_d = ptr_q - 1'b1;
      ACT_VAL_UP: begin we_o = 1'b1; wdata_o = rdata_i + 1'b1; end
      ACT_VAL_DN: begin we_o = 1'b1; wdata_o = rdata_i - 1'b1; end
      default: ;
    endcase
  end

  // Internal read follows the next pointer; on value edits it equals ptr_q
  assign raddr_o = ptr_d;
  assign waddr_o = ptr_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ptr_q <= '0;
      val_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      val_q <= we_o ? wdata_o : rdata_i;
    end
  end

  assign ptr_o = ptr_q;
  assign val_o = val_q;
endmodule

// File: rtl/btn_regfile_editor.sv
module btn_regfile_editor
  import btn_edit_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [BTN_N-1:0] btn_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [AW-1:0]    ptr_o,
  output logic [DW-1:0]    val_o
);
  edit_act_e        act;
  logic [BTN_N-1:0] btn_prev;
  logic [AW-1:0]    raddr, waddr;
  logic [DW-1:0]    rdata, wdata;
  logic             we;

  btn_press_detect u_detect (
    .clk_i      (clk_i),
    .btn_i      (btn_i),
    .btn_prev_o (btn_prev),
    .act_o      (act)
  );

  edit_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .act_i   (act),
    .rdata_i (rdata),
    .raddr_o (raddr),
    .we_o    (we),
    .waddr_o (waddr),
    .wdata_o (wdata),
    .ptr_o   (ptr_o),
    .val_o   (val_o)
  );

  regfile_2p #(.DW(DW), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .iaddr_i (raddr),
    .idata_o (rdata),
    .xaddr_i (rd_addr_i),
    .xdata_o (rd_data_o)
  );
endmodule

// File: rtl/btn_regfile_editor_checker.sv
module btn_regfile_editor_checker #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic [3:0]    btn_i,
  input logic [3:0]    btn_prev,
  input logic [AW-1:0] ptr_o,
  input logic [DW-1:0] val_o
);
  a_r2_ptr_up: assert property (@(posedge clk_i) disable iff (rst_i)
    (btn_i == 4'b1000 && !btn_prev[3]) |=> ptr_o == AW'($past(ptr_o) + 1'b1));

  a_r3_ptr_down: assert property (@(posedge clk_i) disable iff (rst_i)
    (btn_i == 4'b0100 && !btn_prev[2]) |=> ptr_o == AW'($past(ptr_o) - 1'b1));

  a_r4_val_up: assert property (@(posedge clk_i) disable iff (rst_i)
    (btn_i == 4'b0010 && !btn_prev[1]) |=> val_o == DW'($past(val_o) + 1'b1));

  a_r5_val_down: assert property (@(posedge clk_i) disable iff (rst_i)
    (btn_i == 4'b0001 && !btn_prev[0]) |=> val_o == DW'($past(val_o) - 1'b1));

  a_r6_multi_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    ($countones(btn_i) > 1) |=> ($stable(ptr_o) && $stable(val_o)));

  a_r7_held_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    (btn_i == btn_prev) |=> ($stable(ptr_o) && $stable(val_o)));
endmodule

bind btn_regfile_editor btn_regfile_editor_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .btn_i    (btn_i),
  .btn_prev (btn_prev),
  .ptr_o    (ptr_o),
  .val_o    (val_o)
);

// File: tb/btn_regfile_editor_bench.sv
module btn_regfile_editor_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] btn;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic [3:0] ptr;
  logic [7:0] val;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  btn_regfile_editor u_btn_regfile_editor (
    .clk_i(clk), .rst_i(rst), .btn_i(btn), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .ptr_o(ptr), .val_o(val)
  );

  // {buttons, expected pointer, expected value}
  localparam logic [15:0] VEC [27] = '{
    16'h0000, 16'h2001, 16'h2001, 16'h0001, 16'h2002, 16'h0002, // R4, R7
    16'h1001, 16'h0001, 16'h8100, 16'h0100, 16'h11FF, 16'h01FF, // R5, R2
    16'h2100, 16'h0100, 16'h4001, 16'h0001, 16'h4F00, 16'h0F00, // R4 wrap, R3 wrap
    16'h8001, 16'h0001, 16'h6001, 16'h2001, 16'h0001, 16'h9001, // R2 wrap, R6
    16'h0001, 16'h2002, 16'h0002
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1; btn = 4'b0000; rd_addr = 4'd0;
    repeat (3) tick();
    rst = 1'b0;
    chk("R1 reset ptr", ptr, 0);
    chk("R1 reset val", val, 0);
    chk("R1 reset rd_data", rd_data, 0);

    for (int i = 0; i < 27; i++) begin
      btn = VEC[i][15:12];
      tick();
      chk($sformatf("R2..R7 vector %0d ptr", i), ptr, VEC[i][11:8]);
      chk($sformatf("R2..R7 vector %0d val", i), val, VEC[i][7:0]);
    end
    // words now: [0]=2, [1]=0, [15]=0; pointer 0

    // R8 external read, independent of pointer
    rd_addr = 4'd0; tick();
    chk("R8 read addr0", rd_data, 2);
    rd_addr = 4'd1; tick();
    chk("R8 read addr1", rd_data, 0);
    chk("R8 pointer untouched", ptr, 0);

    // R9 read during write to same word
    rd_addr = 4'd0; tick();
    btn = 4'b0010; tick();
    chk("R9 old data on write edge", rd_data, 2);
    chk("R9 selected value", val, 3);
    btn = 4'b0000; tick();
    chk("R9 new data next edge", rd_data, 3);

    // R10 outputs change on the accepting edge
    btn = 4'b1000; #1;
    chk("R10 ptr before edge", ptr, 0);
    tick();
    chk("R10 ptr after edge", ptr, 1);
    chk("R10 val after edge", val, 0);
    btn = 4'b0000; tick();

    // R1 reset clears storage; R11 held button through reset
    rst = 1'b1; btn = 4'b0100;
    repeat (2) tick();
    rst = 1'b0; rd_addr = 4'd0;
    tick();
    chk("R11 held through reset ptr", ptr, 0);
    chk("R1 storage cleared", rd_data, 0);
    tick();
    chk("R11 still held ptr", ptr, 0);
    btn = 4'b0000; tick();
    btn = 4'b1000; tick();
    chk("R2 press after reset", ptr, 1);
    chk("R1 word1 cleared", val, 0);
    btn = 4'b0000; tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule